// File: doc/BRIEF.md
# Coprocessor Bus Hold Arbiter

This block decides, cycle by cycle, which of three parties drives the external memory bus: the CPU core, an external bus master, or a vector coprocessor. The core owns the bus by default. The coprocessor asks for the bus with an internal hold request. It may start an external bus cycle only while its grant, which acts as the hold acknowledge, is high. Each coprocessor grant covers one transaction, which ends when the bus side raises a done handshake. After every coprocessor transaction the arbiter hands the bus back to the core for exactly one cycle. This gives time-critical core code room for one access between coprocessor transactions.

An external hold request always beats the coprocessor. A software hold flag stops the coprocessor from starting new references. If the coprocessor asks for the bus while the flag is set, it is parked in a wait state, and the core keeps the bus until software clears the flag. A transaction that is already running when the flag is set runs to its end.

All grants come from a registered state. A change on any input appears on the grant outputs one clock edge later.

Top module: `cop_bus_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the arbiter returns to core ownership: after that edge `core_gnt`=1 and `ext_gnt`, `cop_gnt` and `cop_stalled` are 0.
- R2: `cop_gnt` rises only after an edge at which `cop_hold_req` was 1. From core ownership with `ext_hold_req`=0 and `sw_hold_flag`=0, a request is granted at the next edge.
- R3: When the coprocessor does not hold the bus, `ext_hold_req`=1 at an edge yields `ext_gnt`=1 after that edge, even if `cop_hold_req` is also 1.
- R4: `ext_gnt` stays high while `ext_hold_req` stays 1. After the first edge with `ext_hold_req`=0, `core_gnt` is 1.
- R5: Once high, `cop_gnt` stays high until an edge with `bus_xfer_done`=1. Neither `ext_hold_req` nor `sw_hold_flag` ends it early.
- R6: After the edge that ends a coprocessor transaction, `core_gnt` is 1 for exactly one cycle. A still-pending coprocessor request that is not otherwise blocked is granted at the edge after that.
- R7: While `sw_hold_flag`=1, no new coprocessor grant starts. A coprocessor request that arrives then parks the arbiter with `cop_stalled`=1 and `core_gnt`=1.
- R8: In the parked state, clearing `sw_hold_flag` while `cop_hold_req` stays 1 gives `cop_gnt`=1 and `cop_stalled`=0 after the next edge.
- R9: In every cycle exactly one of `core_gnt`, `ext_gnt`, `cop_gnt` is 1.
- R10: In the parked state, dropping `cop_hold_req` returns the arbiter to plain core ownership with `cop_stalled`=0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_hold_req | input | 1 | Hold request from the external bus master |
| cop_hold_req | input | 1 | Internal hold request from the coprocessor |
| sw_hold_flag | input | 1 | Software flag that blocks new coprocessor references |
| bus_xfer_done | input | 1 | Bus side signals the end of the granted coprocessor transaction |
| core_gnt | output | 1 | Core owns the bus |
| ext_gnt | output | 1 | External master owns the bus |
| cop_gnt | output | 1 | Coprocessor owns the bus (hold acknowledge) |
| cop_stalled | output | 1 | Coprocessor request parked by the software flag |

## Verification
The bench runs back-to-back coprocessor transactions with the request held high. This separates a correct single release cycle from a missing one or a longer one. It raises the coprocessor and external requests together from idle to expose the priority order. It also raises the external request in the middle of a coprocessor transaction, to check that the transaction is not preempted and that the handover goes through the release cycle. The software flag is set both before a request and during a running transaction, which tells the parking behaviour apart from completion of work already in flight. The parked state is left once by clearing the flag and once by withdrawing the request.

// File: rtl/cop_arb_pkg.sv
package cop_arb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE_CORE = 3'd0,
        ST_EXT_GRANT = 3'd1,
        ST_COP_GRANT = 3'd2,
        ST_RELEASE   = 3'd3,
        ST_COP_HELD  = 3'd4
    } arb_state_e;

    localparam int STATE_W = $bits(arb_state_e);

    typedef struct packed {
        logic ext_req;
        logic cop_req;
        logic flag;
        logic done;
    } arb_in_t;

    typedef struct packed {
        logic core;
        logic ext;
        logic cop;
        logic stalled;
    } arb_out_t;

    // Choice made whenever the core currently owns the bus.
    function automatic arb_state_e pick_owner(arb_in_t r);
        if (r.ext_req)
            return ST_EXT_GRANT;
        else if (r.cop_req && r.flag)
            return ST_COP_HELD;
        else if (r.cop_req)
            return ST_COP_GRANT;
        else
            return ST_IDLE_CORE;
    endfunction

endpackage

// File: rtl/arb_next_state.sv
module arb_next_state
    import cop_arb_pkg::*;
(
    input  arb_state_e cur,
    input  arb_in_t    req,
    output arb_state_e nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            ST_IDLE_CORE: nxt = pick_owner(req);
            ST_RELEASE:   nxt = pick_owner(req);
            ST_EXT_GRANT: nxt = req.ext_req ? ST_EXT_GRANT : ST_IDLE_CORE;
            ST_COP_GRANT: nxt = req.done ? ST_RELEASE : ST_COP_GRANT;
            ST_COP_HELD: begin
                if (req.ext_req)
                    nxt = ST_EXT_GRANT;
                else if (!req.cop_req)
                    nxt = ST_IDLE_CORE;
                else if (!req.flag)
                    nxt = ST_COP_GRANT;
                else
                    nxt = ST_COP_HELD;
            end
            default: nxt = ST_IDLE_CORE;
        endcase
    end
endmodule

// File: rtl/arb_state_reg.sv
module arb_state_reg
    import cop_arb_pkg::*;
#(
    parameter arb_state_e RESET_STATE = ST_IDLE_CORE
) (
    input  logic       clk,
    input  logic       rst,
    input  arb_state_e nxt,
    output arb_state_e cur
);
    always_ff @(posedge clk) begin
        if (rst)
            cur <= RESET_STATE;
        else
            cur <= nxt;
    end
endmodule

// File: rtl/arb_grant_decode.sv
module arb_grant_decode
    import cop_arb_pkg::*;
(
    input  arb_state_e cur,
    output arb_out_t   gnt
);
    always_comb begin
        gnt = '0;
        unique case (cur)
            ST_EXT_GRANT: gnt.ext  = 1'b1;
            ST_COP_GRANT: gnt.cop  = 1'b1;
            ST_COP_HELD: begin
                gnt.core    = 1'b1;
                gnt.stalled = 1'b1;
            end
            default:      gnt.core = 1'b1;
        endcase
    end
endmodule

// File: rtl/cop_bus_arbiter.sv
module cop_bus_arbiter
    import cop_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic ext_hold_req,
    input  logic cop_hold_req,
    input  logic sw_hold_flag,
    input  logic bus_xfer_done,
    output logic core_gnt,
    output logic ext_gnt,
    output logic cop_gnt,
    output logic cop_stalled
);
    arb_in_t    req;
    arb_out_t   gnt;
    arb_state_e state_q;
    arb_state_e state_d;

    assign req = '{ext_req: ext_hold_req, cop_req: cop_hold_req,
                   flag: sw_hold_flag, done: bus_xfer_done};

    arb_next_state u_next (
        .cur (state_q),
        .req (req),
        .nxt (state_d)
    );

    arb_state_reg #(.RESET_STATE(ST_IDLE_CORE)) u_reg (
        .clk (clk),
        .rst (rst),
        .nxt (state_d),
        .cur (state_q)
    );

    arb_grant_decode u_dec (
        .cur (state_q),
        .gnt (gnt)
    );

    assign core_gnt    = gnt.core;
    assign ext_gnt     = gnt.ext;
    assign cop_gnt     = gnt.cop;
    assign cop_stalled = gnt.stalled;
endmodule

// File: rtl/cop_bus_arbiter_chk.sv
module cop_bus_arbiter_chk (
    input logic clk,
    input logic rst,
    input logic ext_hold_req,
    input logic cop_hold_req,
    input logic sw_hold_flag,
    input logic bus_xfer_done,
    input logic core_gnt,
    input logic ext_gnt,
    input logic cop_gnt,
    input logic cop_stalled
);
    assert_cop_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cop_gnt) |-> $past(cop_hold_req));

    assert_ext_wins_R3: assert property (@(posedge clk) disable iff (rst)
        (!cop_gnt && ext_hold_req) |=> ext_gnt);

    assert_ext_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (ext_gnt && !ext_hold_req) |=> core_gnt);

    assert_cop_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (cop_gnt && !bus_xfer_done) |=> cop_gnt);

    assert_release_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        (cop_gnt && bus_xfer_done) |=> (core_gnt && !cop_stalled));

    assert_flag_blocks_R7: assert property (@(posedge clk) disable iff (rst)
        (!cop_gnt && sw_hold_flag) |=> !cop_gnt);

    assert_one_owner_R9: assert property (@(posedge clk) disable iff (rst)
        $countones({core_gnt, ext_gnt, cop_gnt}) == 1);

    assert_stall_has_core_R7: assert property (@(posedge clk) disable iff (rst)
        cop_stalled |-> core_gnt);
endmodule

bind cop_bus_arbiter cop_bus_arbiter_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .ext_hold_req  (ext_hold_req),
    .cop_hold_req  (cop_hold_req),
    .sw_hold_flag  (sw_hold_flag),
    .bus_xfer_done (bus_xfer_done),
    .core_gnt      (core_gnt),
    .ext_gnt       (ext_gnt),
    .cop_gnt       (cop_gnt),
    .cop_stalled   (cop_stalled)
);

// File: tb/cop_bus_arbiter_bench.sv
module cop_bus_arbiter_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_hold_req = 1'b0;
    logic cop_hold_req = 1'b0;
    logic sw_hold_flag = 1'b0;
    logic bus_xfer_done = 1'b0;
    logic core_gnt, ext_gnt, cop_gnt, cop_stalled;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cop_bus_arbiter u_cop_bus_arbiter (
        .clk           (clk),
        .rst           (rst),
        .ext_hold_req  (ext_hold_req),
        .cop_hold_req  (cop_hold_req),
        .sw_hold_flag  (sw_hold_flag),
        .bus_xfer_done (bus_xfer_done),
        .core_gnt      (core_gnt),
        .ext_gnt       (ext_gnt),
        .cop_gnt       (cop_gnt),
        .cop_stalled   (cop_stalled)
    );

    // One clock edge, then settle away from the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Expected {core, ext, cop, stalled}, plus the one-owner rule (R9).
    task automatic expect_out(input string tag, input logic [3:0] exp);
        logic [3:0] act;
        act = {core_gnt, ext_gnt, cop_gnt, cop_stalled};
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {core,ext,cop,stalled} actual %b expected %b",
                     tag, act, exp);
        end
        n_checks++;
        if ($countones({core_gnt, ext_gnt, cop_gnt}) != 1) begin
            n_fails++;
            $display("FAIL R9: grant count actual %0d expected 1",
                     $countones({core_gnt, ext_gnt, cop_gnt}));
        end
    endtask

    localparam logic [3:0] O_CORE  = 4'b1000;
    localparam logic [3:0] O_EXT   = 4'b0100;
    localparam logic [3:0] O_COP   = 4'b0010;
    localparam logic [3:0] O_PARK  = 4'b1001;

    task automatic t_reset();
        rst = 1'b1;
        step();
        step();
        expect_out("R1 reset", O_CORE);
        rst = 1'b0;
        step();
        expect_out("R1 idle after reset", O_CORE);
    endtask

    task automatic t_back_to_back();
        cop_hold_req = 1'b1;
        step();
        expect_out("R2 grant on request", O_COP);
        step();
        step();
        expect_out("R5 held without done", O_COP);
        bus_xfer_done = 1'b1;
        step();
        expect_out("R6 release cycle", O_CORE);
        bus_xfer_done = 1'b0;
        step();
        expect_out("R6 regrant after one cycle", O_COP);
        bus_xfer_done = 1'b1;
        cop_hold_req = 1'b0;
        step();
        expect_out("R6 release after second", O_CORE);
        bus_xfer_done = 1'b0;
        step();
        expect_out("R2 no grant without request", O_CORE);
    endtask

    task automatic t_ext_priority();
        ext_hold_req = 1'b1;
        cop_hold_req = 1'b1;
        step();
        expect_out("R3 ext beats cop", O_EXT);
        step();
        expect_out("R4 ext held", O_EXT);
        ext_hold_req = 1'b0;
        step();
        expect_out("R4 core after ext drop", O_CORE);
        step();
        expect_out("R2 cop after ext", O_COP);
        bus_xfer_done = 1'b1;
        cop_hold_req = 1'b0;
        step();
        bus_xfer_done = 1'b0;
        step();
        expect_out("R6 back to core", O_CORE);
    endtask

    task automatic t_ext_during_cop();
        cop_hold_req = 1'b1;
        step();
        ext_hold_req = 1'b1;
        step();
        expect_out("R5 ext does not preempt", O_COP);
        bus_xfer_done = 1'b1;
        step();
        expect_out("R6 release before ext", O_CORE);
        bus_xfer_done = 1'b0;
        step();
        expect_out("R3 ext after release", O_EXT);
        ext_hold_req = 1'b0;
        cop_hold_req = 1'b0;
        step();
        expect_out("R4 core after ext", O_CORE);
    endtask

    task automatic t_flag_park();
        sw_hold_flag = 1'b1;
        cop_hold_req = 1'b1;
        step();
        expect_out("R7 parked", O_PARK);
        step();
        step();
        step();
        expect_out("R7 still parked", O_PARK);
        sw_hold_flag = 1'b0;
        step();
        expect_out("R8 grant after flag clear", O_COP);
        sw_hold_flag = 1'b1;
        step();
        expect_out("R5 flag does not cut transaction", O_COP);
        bus_xfer_done = 1'b1;
        step();
        expect_out("R6 release with flag set", O_CORE);
        bus_xfer_done = 1'b0;
        step();
        expect_out("R7 parked after release", O_PARK);
        cop_hold_req = 1'b0;
        step();
        expect_out("R10 request withdrawn", O_CORE);
        cop_hold_req = 1'b1;
        step();
        expect_out("R7 parked again", O_PARK);
        ext_hold_req = 1'b1;
        step();
        expect_out("R3 ext from parked", O_EXT);
        ext_hold_req = 1'b0;
        cop_hold_req = 1'b0;
        sw_hold_flag = 1'b0;
        step();
        expect_out("R4 core at end", O_CORE);
    endtask

    initial begin
        #1;
        t_reset();
        t_back_to_back();
        t_ext_priority();
        t_ext_during_cop();
        t_flag_park();
        t_reset();
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end
endmodule